// File: doc/BRIEF.md
# Counted Handshake Bus Receiver

This block pulls a preset number of 9-bit bus values (eight data bits and one parity bit) from a parallel bus. It uses an interlocked request/acknowledge handshake in which both strobes are active low. A controller loads the transfer length through a one-cycle start strobe, then runs one handshake per value. Each value is pushed out on a valid/ready stream as a 16-bit word. When the consumer has taken the final word, a one-cycle completion pulse follows.

The length operand is one less than the number of values wanted. The bus value is not taken while the request strobe is low. It is taken in the same clock step that the request strobe is released, from a registered copy of the pins. The acknowledge input is synchronized before any decision is made on it. A full output word holds back the next request, so no sample is ever lost. Transfer lengths are expected to be even.

Top module: `cnt_async_rx`

## Requirements
- R1: After a synchronous reset, req_n is 1, out_valid is 0, busy is 0 and done is 0.
- R2: A start pulse accepted while idle with start_count = N produces exactly N+1 output words. After that, req_n stays high and no further word appears.
- R3: req_n is driven low only after the synchronized acknowledge has been seen high. While ack_n is held low, req_n stays high indefinitely.
- R4: Each output word carries the 9 bus bits in out_data[8:0] and zeros in out_data[15:9]. Words appear in bus order, and each holds the bus value that was present while ack_n was low.
- R5: out_valid rises in the same cycle that req_n returns high.
- R6: req_n is never low while an output word is pending (out_valid high). A stalled consumer delays the next request.
- R7: While out_valid is high and out_ready is low, out_valid stays high and out_data is unchanged on the next cycle.
- R8: busy is high from the cycle after an accepted start until the final word is accepted. In the following cycle busy is low and done is high for exactly one cycle.
- R9: A start pulse that arrives while busy is high is ignored. The running transfer keeps its original length.
- R10: With a free output slot, req_n goes high on the third rising edge after ack_n falls. req_n goes low on the third rising edge after ack_n rises (two synchronizer flops plus one state register).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle request to begin a transfer |
| start_count | input | 16 | Number of values to receive, minus one |
| bus_pins | input | 9 | Bus data bits 7:0 and parity bit 8 |
| ack_n | input | 1 | Acknowledge strobe from the bus, active low, asynchronous |
| req_n | output | 1 | Request strobe to the bus, active low |
| out_valid | output | 1 | Output word present |
| out_data | output | 16 | Output word: bus value in bits 8:0, zero above |
| out_ready | input | 1 | Consumer takes the word when high with out_valid |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse after the last word is taken |

## Verification
The checker assumes that start_count is odd whenever a start is accepted, so that every transfer length is even. It also assumes that the bus side follows the interlock: the bus value is held steady from before ack_n falls until req_n has returned high. The bench's bus model sets the value and lowers ack_n on the same falling clock edge. It changes the pins only after it sees req_n high, and it issues starts only with odd operands of 1 to 7. The consumer model sweeps always-ready, one-in-three and bursty ready patterns, so that every stall path is driven.

// File: rtl/rx_pkg.sv
package rx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT_HI,
    ST_REQ,
    ST_DRAIN
  } rx_state_e;
endpackage

// File: rtl/rx_sync.sv
// Multi-flop synchronizer; resets to the released (high) level.
module rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sr <= '1;
        else     sr <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sr <= '1;
        else     sr <= {sr[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = sr[STAGES-1];
endmodule

// File: rtl/rx_pinreg.sv
// Input register for the bus pins.
module rx_pinreg #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end
endmodule

// File: rtl/rx_outreg.sv
// Single-entry output register: zero-pads the captured bus value.
module rx_outreg #(
  parameter int DW = 9,
  parameter int OW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [DW-1:0] din,
  input  logic          ready,
  output logic          valid,
  output logic [OW-1:0] data,
  output logic          accept
);
  localparam int PAD = OW - DW;

  assign accept = valid & ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      data  <= '0;
    end else if (load) begin
      valid <= 1'b1;
      data  <= {{PAD{1'b0}}, din};
    end else if (accept) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/rx_ctrl.sv
// Handshake sequencer with byte countdown.
module rx_ctrl
  import rx_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [CW-1:0] start_count,
  input  logic          ack_s,
  input  logic          slot_free,
  input  logic          accept,
  output logic          req_n,
  output logic          busy,
  output logic          done,
  output logic          capture
);
  rx_state_e     state;
  logic [CW-1:0] remain;

  // Bus value is taken in the step that releases REQ.
  assign capture = (state == ST_REQ) && !ack_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      remain <= '0;
      req_n  <= 1'b1;
      busy   <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            remain <= start_count;
            busy   <= 1'b1;
            state  <= ST_WAIT_HI;
          end
        end
        ST_WAIT_HI: begin
          if (ack_s && slot_free) begin
            req_n <= 1'b0;
            state <= ST_REQ;
          end
        end
        ST_REQ: begin
          if (!ack_s) begin
            req_n <= 1'b1;
            if (remain == '0) begin
              state <= ST_DRAIN;
            end else begin
              remain <= remain - CW'(1);
              state  <= ST_WAIT_HI;
            end
          end
        end
        ST_DRAIN: begin
          if (accept) begin
            busy  <= 1'b0;
            done  <= 1'b1;
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cnt_async_rx.sv
module cnt_async_rx #(
  parameter int DW          = 9,
  parameter int OW          = 16,
  parameter int CW          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [CW-1:0] start_count,
  input  logic [DW-1:0] bus_pins,
  input  logic          ack_n,
  output logic          req_n,
  output logic          out_valid,
  output logic [OW-1:0] out_data,
  input  logic          out_ready,
  output logic          busy,
  output logic          done
);
  logic          ack_seen;
  logic [DW-1:0] pins_q;
  logic          capture;
  logic          accept;

  rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (ack_n),
    .q   (ack_seen)
  );

  rx_pinreg #(.W(DW)) u_pins (
    .clk (clk),
    .rst (rst),
    .d   (bus_pins),
    .q   (pins_q)
  );

  rx_ctrl #(.CW(CW)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .start_count (start_count),
    .ack_s       (ack_seen),
    .slot_free   (!out_valid),
    .accept      (accept),
    .req_n       (req_n),
    .busy        (busy),
    .done        (done),
    .capture     (capture)
  );

  rx_outreg #(.DW(DW), .OW(OW)) u_out (
    .clk    (clk),
    .rst    (rst),
    .load   (capture),
    .din    (pins_q),
    .ready  (out_ready),
    .valid  (out_valid),
    .data   (out_data),
    .accept (accept)
  );
endmodule

// File: rtl/rx_chk.sv
module rx_chk #(
  parameter int DW = 9,
  parameter int OW = 16,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic [CW-1:0] start_count,
  input logic          ack_seen,
  input logic          req_n,
  input logic          out_valid,
  input logic [OW-1:0] out_data,
  input logic          out_ready,
  input logic          busy,
  input logic          done
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (req_n && !out_valid && !busy && !done));

  // R2 (input rule: even transfer length)
  even_len_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |-> start_count[0]);

  // R3
  req_after_ack_hi_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(req_n) |-> $past(ack_seen));

  // R3
  req_release_on_ack_lo_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(req_n) |-> !$past(ack_seen));

  // R4
  pad_zero_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_data[OW-1:DW] == '0));

  // R5
  word_on_release_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(req_n) |-> $rose(out_valid));

  // R6
  no_req_when_full_chk: assert property (@(posedge clk) disable iff (rst)
    !req_n |-> !out_valid);

  // R7
  hold_stalled_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R9
  busy_from_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));
endmodule

bind cnt_async_rx rx_chk #(.DW(DW), .OW(OW), .CW(CW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .start       (start),
  .start_count (start_count),
  .ack_seen    (ack_seen),
  .req_n       (req_n),
  .out_valid   (out_valid),
  .out_data    (out_data),
  .out_ready   (out_ready),
  .busy        (busy),
  .done        (done)
);

// File: tb/sim_cnt_async_rx.sv
`timescale 1ns/1ps
module sim_cnt_async_rx;
  localparam int DW = 9;
  localparam int OW = 16;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst;
  logic          start;
  logic [CW-1:0] start_count;
  logic [DW-1:0] bus_pins;
  logic          ack_n;
  logic          req_n;
  logic          out_valid;
  logic [OW-1:0] out_data;
  logic          out_ready;
  logic          busy;
  logic          done;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  cnt_async_rx #(.DW(DW), .OW(OW), .CW(CW)) u0 (
    .clk(clk), .rst(rst), .start(start), .start_count(start_count),
    .bus_pins(bus_pins), .ack_n(ack_n), .req_n(req_n),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
    .busy(busy), .done(done)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pat(input int seed, input int k);
    return DW'((seed * 53 + k * 29 + 7) % 512);
  endfunction

  // Bus side: holds value from ack fall until REQ release.
  task automatic responder(input int n, input int seed, input bit lat);
    for (int k = 0; k < n; k++) begin
      int w;
      if (k == 0) ack_n = 1'b1;
      w = 0;
      while (req_n) begin @(negedge clk); w++; end
      if (lat && k > 0) chk(w == 3, "R10 req assert latency", w, 3);
      bus_pins = pat(seed, k);
      ack_n    = 1'b0;
      w = 0;
      do begin @(negedge clk); w++; end while (!req_n);
      chk(w == 3, "R10 req release latency", w, 3);
      chk(out_valid, "R5 word appears with REQ release", int'(out_valid), 1);
      ack_n    = 1'b1;
      bus_pins = ~pat(seed, k);
    end
  endtask

  task automatic consumer(input int n, input int seed, input int mode);
    int got = 0;
    int cyc = 0;
    bit stalled = 0;
    logic [OW-1:0] held = '0;
    while (got < n) begin
      @(negedge clk);
      cyc++;
      if (stalled) begin
        chk(out_valid && out_data == held, "R7 word held while stalled", int'(out_data), int'(held));
        chk(req_n, "R6 no REQ while word pending", int'(req_n), 1);
      end
      stalled = 0;
      case (mode)
        0:       out_ready = 1'b1;
        1:       out_ready = (cyc % 3 == 0);
        default: out_ready = (cyc % 8 >= 6);
      endcase
      if (out_valid && out_ready) begin
        chk(out_data == {7'b0, pat(seed, got)}, "R4 word content", int'(out_data), int'(pat(seed, got)));
        chk(busy, "R8 busy until last accept", int'(busy), 1);
        got++;
      end else if (out_valid) begin
        stalled = 1;
        held    = out_data;
      end
    end
    @(negedge clk);
    out_ready = 1'b0;
    chk(done && !busy, "R8 done pulse with busy low", int'({done, busy}), 2);
    @(negedge clk);
    chk(!done, "R8 done lasts one cycle", int'(done), 0);
  endtask

  task automatic run_xfer(input int n, input int seed, input int mode,
                          input bit hold_ack, input bit inject);
    @(negedge clk);
    start = 1'b1;
    start_count = CW'(n - 1);
    @(negedge clk);
    start = 1'b0;
    chk(busy, "R8 busy after start", int'(busy), 1);
    if (hold_ack) begin
      repeat (10) @(negedge clk);
      chk(req_n, "R3 no REQ while ACK held low", int'(req_n), 1);
    end
    fork
      responder(n, seed, mode == 0);
      consumer(n, seed, mode);
      if (inject) begin
        // R9: second start during a transfer must be ignored
        repeat (8) @(negedge clk);
        start = 1'b1;
        start_count = CW'(1);
        @(negedge clk);
        start = 1'b0;
      end
    join
    repeat (20) @(negedge clk);
    chk(req_n && !out_valid && !busy, "R2 stop after count+1 words",
        int'({req_n, out_valid, busy}), 4);
    if (inject)
      chk(!busy && req_n, "R9 restart ignored", int'(busy), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    start = 1'b0;
    start_count = '0;
    bus_pins = '0;
    ack_n = 1'b1;
    out_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(req_n, "R1 req_n after reset", int'(req_n), 1);
    chk(!out_valid, "R1 out_valid after reset", int'(out_valid), 0);
    chk(!busy, "R1 busy after reset", int'(busy), 0);
    chk(!done, "R1 done after reset", int'(done), 0);

    ack_n = 1'b0;
    run_xfer(2, 1, 0, 1'b1, 1'b0);

    for (int m = 0; m < 3; m++) begin
      for (int n = 2; n <= 8; n += 2) begin
        run_xfer(n, 10 * m + n, m, 1'b0, 1'b0);
      end
    end

    run_xfer(4, 77, 0, 1'b0, 1'b1);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule